// File: doc/BRIEF.md
# Reset Controller with Sticky Cause Register

This block gathers every reset request in a small microcontroller into one system reset. The requests are supply power-up, low-supply (brownout), watchdog expiry, firmware request, an external pin and a protection fault. Any active request asserts the reset. After the last request goes away, the reset stays asserted for a fixed stretch and then drops on a clock edge. The power-up request also resets the controller itself, asynchronously. Every other request is sampled on the clock, and the external pin first passes through a two-flop synchronizer.

A small register window lets firmware find out why the last reset happened. The firmware, fault and watchdog resets each leave a sticky flag. The supply and pin resets clear all flags, so an empty flag set means a cold start. The watchdog is built in. It comes up armed with a default limit, firmware reloads it through a kick register, and only one exact 32-bit key written to the key register disarms it. Any system reset rearms the watchdog and restores its default limit.

Register window (3-bit address):
- 0: cause flags. Bit 0 is watchdog, bit 1 is firmware, bit 2 is fault. Writing a one to a bit clears that bit.
- 1: watchdog limit (read/write).
- 2: kick. Any write reloads the watchdog counter.
- 3: disarm key (write only).
- 4: state. Bit 0 reads one while the watchdog is armed.

Top module: `rst_ctrl`

## Requirements
- R1: While `por_req` is high, `sys_rst` is high. After `por_req` falls, `sys_rst` goes low on the 16th rising edge.
- R2: When `bod_req`, `soft_req`, `fault_req` or a watchdog expiry is sampled on an edge, `sys_rst` is high after that edge. It falls on the 16th edge after the last edge that sampled a request.
- R3: A rise of `xres_pin` reaches `sys_rst` on the third rising edge: two synchronizer flops, then the stretch register.
- R4: A watchdog reset sets cause bit 0, a firmware reset sets bit 1 and a fault reset sets bit 2.
- R5: Cause bits that are already set stay set through firmware, fault and watchdog resets.
- R6: Power-up, brownout and external-pin resets clear all three cause bits. After power-up the cause register reads 0.
- R7: Writing to address 0 clears exactly the cause bits whose data bit is one. The other bits are unchanged.
- R8: The watchdog is armed after reset with a limit of 1000. After a kick with limit L, `sys_rst` rises on edge L+1 after the kick edge.
- R9: Writing 0xACED8865 to address 3 disarms the watchdog (state bit 0 reads 0, and no expiry occurs). Any other value leaves it armed.
- R10: Every system reset rearms the watchdog and returns its limit to 1000.
- R11: Register writes made while `sys_rst` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| por_req | input | 1 | Power-up request; asynchronous reset of the controller |
| bod_req | input | 1 | Low-supply request, synchronous |
| xres_pin | input | 1 | External reset pin, asynchronous |
| soft_req | input | 1 | Firmware reset request |
| fault_req | input | 1 | Protection fault request |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Write address |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 3 | Read address |
| bus_rdata | output | 32 | Read data, combinational |
| sys_rst | output | 1 | Registered system reset |

## Verification
The bench counts the stretch edge by edge for several sources. A design that is off by one would release one cycle early or late. It also times the pin path from the pin edge, so a missing or extra synchronizer stage moves the reset by a cycle. The cause bits are driven through warm resets, a cold reset and selective write-one-to-clear patterns; a design that wiped the flags on every reset, or cleared whole bytes, would read back the wrong value. The watchdog checks use a key that differs from the right one in its lowest bit, writes made during reset, and a watchdog expiry measured against the programmed limit. A design that matched the key partially or acted on writes during reset would leave the watchdog disarmed or fire at the wrong time.

// File: rtl/rst_ctrl.sv
module rst_ctrl #(
  parameter int          STRETCH  = 16,
  parameter int          DOG_W    = 16,
  parameter int          DOG_INIT = 1000,
  parameter logic [31:0] DOG_KEY  = 32'hACED8865
) (
  input  logic        clk,
  input  logic        por_req,
  input  logic        bod_req,
  input  logic        xres_pin,
  input  logic        soft_req,
  input  logic        fault_req,
  input  logic        bus_we,
  input  logic [2:0]  bus_waddr,
  input  logic [31:0] bus_wdata,
  input  logic [2:0]  bus_raddr,
  output logic [31:0] bus_rdata,
  output logic        sys_rst
);
  localparam int             CW        = $clog2(STRETCH + 1);
  localparam logic [CW-1:0]  HOLD      = CW'(STRETCH);
  localparam logic [DOG_W-1:0] LIM0    = DOG_W'(DOG_INIT);
  localparam logic [2:0]     A_CAUSE   = 3'd0;
  localparam logic [2:0]     A_LIMIT   = 3'd1;
  localparam logic [2:0]     A_KICK    = 3'd2;
  localparam logic [2:0]     A_KEY     = 3'd3;
  localparam logic [2:0]     A_STATE   = 3'd4;

  logic             xs1, xs2;
  logic [CW-1:0]    hold_cnt;
  logic             dog_on;
  logic [DOG_W-1:0] dog_lim, dog_cnt;
  logic [2:0]       cause;

  wire dog_hit = dog_on && (dog_cnt == '0) && !sys_rst;
  wire cold    = bod_req | xs2;
  wire any_req = cold | soft_req | fault_req | dog_hit;
  wire bus_ok  = bus_we && !sys_rst;
  wire [2:0] w1c = (bus_ok && bus_waddr == A_CAUSE) ? bus_wdata[2:0] : 3'b000;

  always_ff @(posedge clk or posedge por_req)
    if (por_req) begin
      xs1 <= 1'b0;
      xs2 <= 1'b0;
    end else begin
      xs1 <= xres_pin;
      xs2 <= xs1;
    end

  always_ff @(posedge clk or posedge por_req)
    if (por_req) begin
      hold_cnt <= HOLD;
      sys_rst  <= 1'b1;
    end else if (any_req) begin
      hold_cnt <= HOLD;
      sys_rst  <= 1'b1;
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
      sys_rst  <= (hold_cnt != CW'(1));
    end else begin
      sys_rst  <= 1'b0;
    end

  always_ff @(posedge clk or posedge por_req)
    if (por_req)   cause <= 3'b000;
    else if (cold) cause <= 3'b000;
    else           cause <= (cause & ~w1c) | {fault_req, soft_req, dog_hit};

  always_ff @(posedge clk or posedge por_req)
    if (por_req || sys_rst) begin
      dog_on  <= 1'b1;
      dog_lim <= LIM0;
      dog_cnt <= LIM0;
    end else begin
      if (bus_ok && bus_waddr == A_LIMIT) dog_lim <= bus_wdata[DOG_W-1:0];
      if (bus_ok && bus_waddr == A_KEY && bus_wdata == DOG_KEY) dog_on <= 1'b0;
      if (bus_ok && bus_waddr == A_KICK) dog_cnt <= dog_lim;
      else if (dog_on && dog_cnt != '0)  dog_cnt <= dog_cnt - 1'b1;
    end

  always_comb begin
    bus_rdata = '0;
    case (bus_raddr)
      A_CAUSE: bus_rdata[2:0]       = cause;
      A_LIMIT: bus_rdata[DOG_W-1:0] = dog_lim;
      A_STATE: bus_rdata[0]         = dog_on;
      default: bus_rdata            = '0;
    endcase
  end
endmodule

module rst_ctrl_chk (
  input logic       clk,
  input logic       por_req,
  input logic       bod_req,
  input logic       soft_req,
  input logic       fault_req,
  input logic       xs2,
  input logic       dog_hit,
  input logic [2:0] cause,
  input logic       sys_rst
);
  AST_REQ_TO_RST: assert property (@(posedge clk) disable iff (por_req)
    (bod_req || soft_req || fault_req || dog_hit) |=> sys_rst); // R2
  AST_QUIET_RELEASE: assert property (@(posedge clk) disable iff (por_req)
    $fell(sys_rst) |-> $past(!(bod_req || soft_req || fault_req || xs2))); // R2
  AST_COLD_CLEARS: assert property (@(posedge clk) disable iff (por_req)
    (bod_req || xs2) |=> (cause == 3'b000)); // R6
  AST_SOFT_FLAG: assert property (@(posedge clk) disable iff (por_req)
    (soft_req && !bod_req && !xs2) |=> cause[1]); // R4
  AST_DOG_FLAG: assert property (@(posedge clk) disable iff (por_req)
    (dog_hit && !bod_req && !xs2) |=> (cause[0] && sys_rst)); // R8
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (por_req)
    (sys_rst && !bod_req && !xs2) |=> ((cause & $past(cause)) == $past(cause))); // R5
endmodule

bind rst_ctrl rst_ctrl_chk u_chk (
  .clk(clk), .por_req(por_req), .bod_req(bod_req), .soft_req(soft_req),
  .fault_req(fault_req), .xs2(xs2), .dog_hit(dog_hit), .cause(cause),
  .sys_rst(sys_rst)
);

// File: tb/rst_ctrl_test.sv
module rst_ctrl_test;
  logic        clk = 1'b0;
  logic        por_req = 1'b1, bod_req = 1'b0, xres_pin = 1'b0;
  logic        soft_req = 1'b0, fault_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_waddr = '0, bus_raddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rst_ctrl uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_raddr = a; #1; v = bus_rdata;
  endtask

  task automatic count_release(output int n);
    n = 0;
    while (sys_rst && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic pulse(input int kind, input string tag);
    int n;
    @(negedge clk);
    case (kind) 0: bod_req = 1; 1: soft_req = 1; default: fault_req = 1; endcase
    @(negedge clk);
    bod_req = 0; soft_req = 0; fault_req = 0;
    chk({tag, " R2 reset asserted"}, sys_rst, 1'b1);
    count_release(n);
    chk({tag, " R2 stretch length"}, n, 16);
  endtask

  task automatic t_power_up;
    logic [31:0] v; int n;
    repeat (3) @(negedge clk);
    chk("R1 held during power-up", sys_rst, 1'b1);
    por_req = 1'b0;
    count_release(n);
    chk("R1 release after power-up", n, 16);
    rd(0, v); chk("R6 cause zero after power-up", v, 0);
    rd(4, v); chk("R8 watchdog armed at start", v, 1);
    rd(1, v); chk("R10 default limit", v, 1000);
  endtask

  task automatic t_warm;
    logic [31:0] v;
    pulse(1, "soft");
    rd(0, v); chk("R4 firmware flag", v, 3'b010);
    pulse(2, "fault");
    rd(0, v); chk("R4 R5 fault flag keeps firmware flag", v, 3'b110);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(0, 32'h0000_0002);
    rd(0, v); chk("R7 clear firmware bit only", v, 3'b100);
    wr(0, 32'hFFFF_FFF8);
    rd(0, v); chk("R7 zeros in low bits clear nothing", v, 3'b100);
    wr(0, 32'h0000_0004);
    rd(0, v); chk("R7 clear fault bit", v, 3'b000);
  endtask

  task automatic t_dog;
    logic [31:0] v; int n;
    pulse(1, "soft pre-dog");
    wr(1, 32'd20);
    wr(2, 32'd0);
    n = 0;
    while (!sys_rst && n < 5000) begin @(negedge clk); n++; end
    chk("R8 expiry at limit+1", n, 21);
    count_release(n);
    rd(0, v); chk("R4 R5 watchdog flag plus firmware flag", v, 3'b011);
    rd(1, v); chk("R10 limit restored", v, 1000);
    rd(4, v); chk("R10 rearmed after expiry", v, 1);
  endtask

  task automatic t_key;
    logic [31:0] v; int n;
    wr(3, 32'hACED8864);
    rd(4, v); chk("R9 wrong key ignored", v, 1);
    wr(3, 32'hACED8865);
    rd(4, v); chk("R9 right key disarms", v, 0);
    n = 0;
    repeat (1300) begin @(negedge clk); if (sys_rst) n++; end
    chk("R9 no expiry while disarmed", n, 0);
    pulse(2, "fault rearm");
    rd(4, v); chk("R10 rearmed by fault reset", v, 1);
  endtask

  task automatic t_ignore;
    logic [31:0] v; int n;
    rd(0, v);
    @(negedge clk); soft_req = 1;
    @(negedge clk); soft_req = 0;
    wr(3, 32'hACED8865);
    wr(0, 32'h7);
    wr(1, 32'd5);
    count_release(n);
    rd(4, v); chk("R11 key write during reset ignored", v, 1);
    rd(0, v); chk("R11 clear during reset ignored", v, 3'b111);
    rd(1, v); chk("R11 limit write during reset ignored", v, 1000);
  endtask

  task automatic t_bod;
    logic [31:0] v;
    pulse(0, "brownout");
    rd(0, v); chk("R6 brownout clears flags", v, 0);
  endtask

  task automatic t_pin;
    logic [31:0] v; int n;
    pulse(1, "soft pre-pin");
    @(negedge clk); xres_pin = 1;
    @(negedge clk); chk("R3 no reset after one edge", sys_rst, 0);
    @(negedge clk); chk("R3 no reset after two edges", sys_rst, 0);
    @(negedge clk); chk("R3 reset on third edge", sys_rst, 1);
    repeat (4) @(negedge clk);
    xres_pin = 0;
    count_release(n);
    chk("R3 pin reset stretch", n, 18);
    rd(0, v); chk("R6 pin reset clears flags", v, 0);
  endtask

  initial begin
    t_power_up();
    t_warm();
    t_w1c();
    t_dog();
    t_key();
    t_ignore();
    t_bod();
    t_pin();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule